// File: doc/BRIEF.md
# EPP Host Cycle Engine

This block sits between a host register bus and an Enhanced Parallel Port peripheral. When the host reads or writes one of the EPP registers, the block runs a complete peripheral transfer. It stalls the host through a ready output, waits for the peripheral's wait line, drives or samples the parallel data lines and pulses either the address strobe or the data strobe. A bus-stall watchdog counts from the start of each host access. If the peripheral never finishes, the cycle is cut short, a sticky timeout flag is raised and the host is released.

When no EPP transfer is running, the port acts as a plain or bidirectional printer port. The data latch, the three control lines and the data direction all come from a local control register. Two more rules apply during an EPP transfer. A set strobe bit in the control register forces the data lines to drive and holds the write line low. A set direction bit turns a host write into a peripheral read, and no error is reported.

Top module: `eppCycleEngine`

## Requirements
- R1: After reset, hostReady is high, all three peripheral strobes and nWriteOut are high, pdOe is 1 and the status register (offset 1) reads 0.
- R2: Outside an EPP transfer, pdOut equals the data latch (offset 0). pdOe is the inverse of control bit 5 (direction). nStrobeOut, nAutoFdOut and nInitOut are the inverses of control bits 0, 1 and 2. Reading offset 0 with bit 5 set returns pdIn.
- R3: With eppModeEn=1, a host write to offset 3 pulses nAddrStb and a write to offsets 4 to 7 pulses nDataStb. While that strobe is low, the host byte is on pdOut, pdOe is 1 and nWriteOut is 0. The two strobes are never low together.
- R4: A strobe falls only after the synchronized nWaitIn has been seen low. It rises only after nWaitIn has been seen high, or on a timeout abort.
- R5: hostReady is low from the cycle an EPP access is presented until that transfer ends. While either peripheral strobe is low, hostReady is low.
- R6: An EPP read keeps pdOe 0 and nWriteOut 1 during the strobe. It returns on hostRdata the pdIn byte sampled when nWaitIn is seen high.
- R7: If a transfer is not done within TMO_US microseconds (500 clocks at the defaults), it is aborted. Status bit 0 is set, the strobes and nWriteOut return high, and hostReady rises one clock after the limit. A read aborted this way returns 8'hFF.
- R8: Status bit 0 is cleared by a read of offset 1 (the read still returns the set value), or by a write to offset 1 with data bit 0 set. A write with data bit 0 clear leaves it set.
- R9: With control bit 0 set, an EPP read drives pdOe=1 and nWriteOut=0 during its strobe.
- R10: With control bit 5 set, an EPP write runs on the peripheral as a read (pdOe 0, nWriteOut 1) and does not set the timeout flag.
- R11: With eppModeEn=0, accesses to offsets 3 to 7 produce no strobe and hostReady stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| eppModeEn | input | 1 | Enables the EPP registers at offsets 3 to 7 |
| hostAddr | input | 3 | Register offset |
| hostRdN | input | 1 | Host read strobe, active low, held until hostReady |
| hostWrN | input | 1 | Host write strobe, active low, held until hostReady |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data |
| hostReady | output | 1 | Low while the host access is stalled |
| pdIn | input | 8 | Parallel data lines as received |
| pdOut | output | 8 | Parallel data lines as driven |
| pdOe | output | 1 | Drive enable for pdOut |
| nWriteOut | output | 1 | Peripheral write indicator, low for a write |
| nDataStb | output | 1 | Data strobe, active low |
| nAddrStb | output | 1 | Address strobe, active low |
| nWaitIn | input | 1 | Peripheral wait/acknowledge line, asynchronous |
| nStrobeOut | output | 1 | Printer strobe line |
| nAutoFdOut | output | 1 | Printer auto-feed line |
| nInitOut | output | 1 | Printer init line |

## Verification
Register accesses at offsets 0 to 2 finish in the cycle they are presented: hostReady stays high and a write lands on the next rising edge. The bench therefore samples read data before that edge and checks the register state on the following falling edge. An EPP transfer holds hostReady low for a count of cycles set by the two-flop wait synchronizer and the peripheral model's reply delay. The bench polls hostReady on falling edges and collects the data there. The peripheral model records pdOut, pdOe, nWriteOut and which strobe was active on the falling edge where it replies. A timed-out access must release the host after 500 to 502 low cycles, which the bench counts exactly.

// File: rtl/eppPkg.sv
package eppPkg;
  localparam int CTL_STB  = 0;
  localparam int CTL_AFD  = 1;
  localparam int CTL_INIT = 2;
  localparam int CTL_DIR  = 5;

  localparam logic [2:0] OFS_DATA   = 3'd0;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_EADDR  = 3'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAITRDY, ST_SETUP, ST_STB, ST_DONE
  } eppState_t;

  typedef struct packed {
    logic capWr;
    logic capRd;
    logic setTmo;
    logic inCycle;
    logic isWrite;
    logic dataStb;
    logic addrStb;
  } eppStrobe_t;
endpackage

// File: rtl/eppCtrl.sv
module eppCtrl
  import eppPkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int TMO_US = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eppModeEn,
  input  logic [2:0] hostAddr,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic       dirBit,
  input  logic       waitS,
  output eppStrobe_t st,
  output logic       hostReady
);
  localparam int TMO_CYC = (CLK_HZ / 1_000_000) * TMO_US;
  localparam int CW      = (TMO_CYC > 2) ? $clog2(TMO_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TMO_CYC - 1);

  eppState_t state, nextState;
  logic [CW-1:0] cnt;
  logic curWrite, curAddr;
  logic hostReq, eppHit, tmoHit, busy;

  assign hostReq = !hostRdN || !hostWrN;
  assign eppHit  = eppModeEn && hostReq && (hostAddr >= OFS_EADDR);
  assign tmoHit  = (cnt == CNT_LAST);
  assign busy    = (state == ST_WAITRDY) || (state == ST_SETUP) || (state == ST_STB);

  always_comb begin
    nextState = state;
    st = '0;
    st.isWrite = curWrite;
    st.inCycle = (state == ST_SETUP) || (state == ST_STB);
    st.dataStb = (state == ST_STB) && !curAddr;
    st.addrStb = (state == ST_STB) && curAddr;
    unique case (state)
      ST_IDLE: if (eppHit) begin
        nextState = ST_WAITRDY;
        st.capWr  = 1'b1;
      end
      ST_WAITRDY: begin
        if (!waitS) nextState = ST_SETUP;
        else if (tmoHit) begin
          nextState = ST_DONE;
          st.setTmo = 1'b1;
        end
      end
      ST_SETUP: nextState = ST_STB;
      ST_STB: begin
        if (waitS) begin
          nextState = ST_DONE;
          st.capRd  = 1'b1;
        end else if (tmoHit) begin
          nextState = ST_DONE;
          st.setTmo = 1'b1;
        end
      end
      ST_DONE: if (!hostReq) nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign hostReady = !(busy || ((state == ST_IDLE) && eppHit));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      curWrite <= 1'b0;
      curAddr  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) cnt <= '0;
      else if (busy && !tmoHit) cnt <= cnt + CW'(1);
      if (st.capWr) begin
        curWrite <= !hostWrN && !dirBit;
        curAddr  <= (hostAddr == OFS_EADDR);
      end
    end
  end
endmodule

// File: rtl/eppDatapath.sv
module eppDatapath
  import eppPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  eppStrobe_t st,
  input  logic [2:0] hostAddr,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  input  logic [7:0] pdIn,
  output logic [7:0] pdOut,
  output logic       pdOe,
  output logic       nWriteOut,
  output logic       nDataStb,
  output logic       nAddrStb,
  output logic       nStrobeOut,
  output logic       nAutoFdOut,
  output logic       nInitOut,
  output logic       dirBit,
  output logic       tmoFlag
);
  logic [7:0] dataReg, ctrlReg, wrLatch, rdLatch;
  logic localWr, forceWr;

  assign localWr = !hostWrN && (hostAddr < OFS_EADDR);
  assign dirBit  = ctrlReg[CTL_DIR];
  assign forceWr = ctrlReg[CTL_STB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      ctrlReg <= '0;
      wrLatch <= '0;
      rdLatch <= '0;
      tmoFlag <= 1'b0;
    end else begin
      if (localWr && hostAddr == OFS_DATA) dataReg <= hostWdata;
      if (localWr && hostAddr == OFS_CTRL) ctrlReg <= hostWdata;
      if (st.capWr) wrLatch <= hostWdata;
      if (st.capRd) rdLatch <= pdIn;
      else if (st.setTmo) rdLatch <= 8'hFF;
      if (st.setTmo) tmoFlag <= 1'b1;
      else if ((localWr && hostAddr == OFS_STATUS && hostWdata[0]) ||
               (!hostRdN && hostAddr == OFS_STATUS)) tmoFlag <= 1'b0;
    end
  end

  always_comb begin
    unique case (hostAddr)
      OFS_DATA:   hostRdata = dirBit ? pdIn : dataReg;
      OFS_STATUS: hostRdata = {7'd0, tmoFlag};
      OFS_CTRL:   hostRdata = ctrlReg;
      default:    hostRdata = rdLatch;
    endcase
  end

  always_comb begin
    if (st.inCycle) begin
      pdOut     = st.isWrite ? wrLatch : dataReg;
      pdOe      = st.isWrite || forceWr;
      nWriteOut = !(st.isWrite || forceWr);
    end else begin
      pdOut     = dataReg;
      pdOe      = !dirBit;
      nWriteOut = 1'b1;
    end
  end

  assign nDataStb   = !st.dataStb;
  assign nAddrStb   = !st.addrStb;
  assign nStrobeOut = !ctrlReg[CTL_STB];
  assign nAutoFdOut = !ctrlReg[CTL_AFD];
  assign nInitOut   = !ctrlReg[CTL_INIT];
endmodule

// File: rtl/eppCycleEngine.sv
module eppCycleEngine
  import eppPkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int TMO_US = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       eppModeEn,
  input  logic [2:0] hostAddr,
  input  logic       hostRdN,
  input  logic       hostWrN,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       hostReady,
  input  logic [7:0] pdIn,
  output logic [7:0] pdOut,
  output logic       pdOe,
  output logic       nWriteOut,
  output logic       nDataStb,
  output logic       nAddrStb,
  input  logic       nWaitIn,
  output logic       nStrobeOut,
  output logic       nAutoFdOut,
  output logic       nInitOut
);
  eppStrobe_t st;
  logic waitMeta, waitS, dirBit, tmoFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitMeta <= 1'b1;
      waitS    <= 1'b1;
    end else begin
      waitMeta <= nWaitIn;
      waitS    <= waitMeta;
    end
  end

  eppCtrl #(.CLK_HZ(CLK_HZ), .TMO_US(TMO_US)) u_ctrl (
    .clk(clk), .rstN(rstN), .eppModeEn(eppModeEn), .hostAddr(hostAddr),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .dirBit(dirBit), .waitS(waitS),
    .st(st), .hostReady(hostReady)
  );

  eppDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .hostAddr(hostAddr), .hostRdN(hostRdN),
    .hostWrN(hostWrN), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .pdIn(pdIn), .pdOut(pdOut), .pdOe(pdOe), .nWriteOut(nWriteOut),
    .nDataStb(nDataStb), .nAddrStb(nAddrStb), .nStrobeOut(nStrobeOut),
    .nAutoFdOut(nAutoFdOut), .nInitOut(nInitOut), .dirBit(dirBit),
    .tmoFlag(tmoFlag)
  );
endmodule

// File: rtl/eppCycleEngineChk.sv
module eppCycleEngineChk (
  input logic clk,
  input logic rstN,
  input logic eppModeEn,
  input logic hostReady,
  input logic pdOe,
  input logic nWriteOut,
  input logic nDataStb,
  input logic nAddrStb,
  input logic waitS,
  input logic tmoFlag
);
  p_stb_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!nDataStb && !nAddrStb));

  p_stb_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(nDataStb) || $rose(nAddrStb)) |-> ($past(waitS) || tmoFlag));

  p_ready_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!nDataStb || !nAddrStb) |-> !hostReady);

  p_abort_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoFlag) |-> (hostReady && nDataStb && nAddrStb));

  p_write_drives_r9: assert property (@(posedge clk) disable iff (!rstN)
    !nWriteOut |-> pdOe);

  p_mode_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!eppModeEn && hostReady && nDataStb && nAddrStb) |=> (nDataStb && nAddrStb));
endmodule

bind eppCycleEngine eppCycleEngineChk u_chk (
  .clk(clk), .rstN(rstN), .eppModeEn(eppModeEn), .hostReady(hostReady),
  .pdOe(pdOe), .nWriteOut(nWriteOut), .nDataStb(nDataStb), .nAddrStb(nAddrStb),
  .waitS(waitS), .tmoFlag(tmoFlag)
);

// File: tb/eppCycleEngine_tb.sv
module eppCycleEngine_tb;
  localparam int CLK_PERIOD = 20;
  localparam int TMO_CYC = 500;

  logic clk = 1'b0, rstN = 1'b0, eppModeEn = 1'b1;
  logic [2:0] hostAddr = '0;
  logic hostRdN = 1'b1, hostWrN = 1'b1;
  logic [7:0] hostWdata = '0, hostRdata, pdIn = '0, pdOut;
  logic hostReady, pdOe, nWriteOut, nDataStb, nAddrStb, nStrobeOut, nAutoFdOut, nInitOut;
  logic nWaitIn;

  // peripheral model state
  logic pWait = 1'b0, pBusy = 1'b0, pHang = 1'b0, prevLow = 1'b0;
  logic errEarly = 1'b0, errRelease = 1'b0;
  int pDelay = 1, pCnt = 0, stbCount = 0;
  logic [7:0] pGot = '0;
  logic pGotWrite = 1'b0, pGotOe = 1'b0, pGotAddr = 1'b0;

  int total = 0, bad = 0;
  bit finished = 0;

  assign nWaitIn = pWait | pBusy;
  always #(CLK_PERIOD/2) clk = ~clk;

  eppCycleEngine u_dut (
    .clk(clk), .rstN(rstN), .eppModeEn(eppModeEn), .hostAddr(hostAddr),
    .hostRdN(hostRdN), .hostWrN(hostWrN), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .pdIn(pdIn), .pdOut(pdOut),
    .pdOe(pdOe), .nWriteOut(nWriteOut), .nDataStb(nDataStb), .nAddrStb(nAddrStb),
    .nWaitIn(nWaitIn), .nStrobeOut(nStrobeOut), .nAutoFdOut(nAutoFdOut),
    .nInitOut(nInitOut)
  );

  initial begin : periph
    forever begin
      @(negedge clk);
      #2;
      if (!nDataStb || !nAddrStb) begin
        if (pBusy) errEarly = 1'b1;
        else if (!pWait && !pHang) begin
          if (pCnt >= pDelay) begin
            pGot = pdOut; pGotWrite = !nWriteOut; pGotOe = pdOe;
            pGotAddr = !nAddrStb; pWait = 1'b1; stbCount++;
          end else pCnt++;
        end
        prevLow = 1'b1;
      end else begin
        if (prevLow && !pWait && !pHang) errRelease = 1'b1;
        prevLow = 1'b0;
        pCnt = 0;
        if (pWait) pWait = 1'b0;
      end
    end
  end

  function automatic bit expAddrStb(input logic [2:0] a);
    return a == 3'd3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic hostAcc(input bit rd, input logic [2:0] a, input logic [7:0] d,
                         output logic [7:0] q, output int lowCyc);
    @(negedge clk);
    hostAddr = a; hostWdata = d;
    if (rd) hostRdN = 1'b0; else hostWrN = 1'b0;
    lowCyc = 0;
    #1;
    while (!hostReady && lowCyc < 2000) begin
      @(negedge clk); #1; lowCyc++;
    end
    q = hostRdata;
    @(negedge clk);
    hostRdN = 1'b1; hostWrN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  initial begin : main
    logic [7:0] q;
    int lc, sc;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(hostReady && nDataStb && nAddrStb && nWriteOut, "R1 idle lines",
        {hostReady, nDataStb, nAddrStb, nWriteOut}, 4'hF);
    chk(pdOe && nStrobeOut, "R1 direction", {pdOe, nStrobeOut}, 2'b11);
    hostAcc(1, 3'd1, 8'h00, q, lc);
    chk(q == 8'h00, "R1 status", q, 0);

    // R2 fallback behaviour
    hostAcc(0, 3'd2, 8'h07, q, lc);
    hostAcc(0, 3'd0, 8'h5A, q, lc);
    #1;
    chk({nStrobeOut, nAutoFdOut, nInitOut} == 3'b000, "R2 control lines",
        {nStrobeOut, nAutoFdOut, nInitOut}, 0);
    chk(pdOe && pdOut == 8'h5A, "R2 data out", pdOut, 8'h5A);
    hostAcc(0, 3'd2, 8'h20, q, lc);
    pdIn = 8'hC3;
    #1;
    chk(!pdOe && nStrobeOut, "R2 reverse direction", pdOe, 0);
    hostAcc(1, 3'd0, 8'h00, q, lc);
    chk(q == 8'hC3, "R2 reverse read", q, 8'hC3);
    hostAcc(0, 3'd2, 8'h04, q, lc);

    // R3 directed address write and data write
    hostAcc(0, 3'd3, 8'hA5, q, lc);
    chk(pGot == 8'hA5 && pGotWrite && pGotOe && pGotAddr, "R3 address write",
        {pGot, pGotWrite, pGotOe, pGotAddr}, {8'hA5, 3'b111});
    chk(lc > 0, "R5 ready stalled", lc, 1);
    hostAcc(0, 3'd7, 8'h1E, q, lc);
    chk(pGot == 8'h1E && pGotWrite && !pGotAddr, "R3 data write",
        {pGot, pGotWrite, pGotAddr}, {8'h1E, 2'b10});

    // R4 peripheral not ready at start
    sc = stbCount;
    pBusy = 1'b1;
    fork
      hostAcc(0, 3'd5, 8'h66, q, lc);
      begin repeat (8) @(negedge clk); pBusy = 1'b0; end
    join
    chk(!errEarly && stbCount == sc + 1 && pGot == 8'h66, "R4 wait precondition",
        {errEarly, pGot}, 8'h66);

    // R6 read
    pdIn = 8'h3B;
    hostAcc(1, 3'd4, 8'h00, q, lc);
    chk(q == 8'h3B && !pGotWrite && !pGotOe, "R6 data read",
        {q, pGotWrite, pGotOe}, {8'h3B, 2'b00});

    // constrained random transfers
    for (int i = 0; i < 24; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      bit rd;
      a = 3'(3 + ($urandom % 5));
      d = 8'($urandom);
      rd = 1'($urandom % 2);
      pDelay = $urandom % 4;
      pdIn = 8'($urandom);
      hostAcc(rd, a, d, q, lc);
      if (rd)
        chk(q == pdIn && !pGotWrite && pGotAddr == expAddrStb(a), "R6 random read",
            q, pdIn);
      else
        chk(pGot == d && pGotWrite && pGotAddr == expAddrStb(a), "R3 random write",
            pGot, d);
    end
    chk(!errRelease, "R4 release after wait", errRelease, 0);
    pDelay = 1;

    // R7 timeout with peripheral silent after strobe
    pHang = 1'b1;
    hostAcc(0, 3'd4, 8'h99, q, lc);
    chk(lc >= TMO_CYC && lc <= TMO_CYC + 2, "R7 abort time", lc, TMO_CYC + 1);
    #1;
    chk(nDataStb && nAddrStb && nWriteOut, "R7 lines released",
        {nDataStb, nAddrStb, nWriteOut}, 3'b111);
    pHang = 1'b0;
    // R8 clear by read
    hostAcc(1, 3'd1, 8'h00, q, lc);
    chk(q[0] == 1'b1, "R8 flag set", q, 1);
    hostAcc(1, 3'd1, 8'h00, q, lc);
    chk(q[0] == 1'b0, "R8 clear on read", q, 0);

    // R7 timeout before peripheral ready, read returns FF
    sc = stbCount;
    pBusy = 1'b1;
    hostAcc(1, 3'd6, 8'h00, q, lc);
    pBusy = 1'b0;
    errEarly = 1'b0;
    chk(q == 8'hFF && stbCount == sc, "R7 aborted read", q, 8'hFF);
    chk(lc >= TMO_CYC && lc <= TMO_CYC + 2, "R7 abort time idle", lc, TMO_CYC + 1);
    // R8 write 0 keeps, write 1 clears
    hostAcc(0, 3'd1, 8'h00, q, lc);
    hostAcc(0, 3'd1, 8'h01, q, lc);
    hostAcc(1, 3'd1, 8'h00, q, lc);
    chk(q[0] == 1'b0, "R8 clear on write one", q, 0);

    // R9 strobe bit forces write direction
    hostAcc(0, 3'd2, 8'h05, q, lc);
    hostAcc(1, 3'd6, 8'h00, q, lc);
    chk(pGotWrite && pGotOe, "R9 forced write", {pGotWrite, pGotOe}, 2'b11);

    // R10 direction bit turns write into read
    hostAcc(0, 3'd2, 8'h24, q, lc);
    hostAcc(0, 3'd4, 8'h3C, q, lc);
    chk(!pGotWrite && !pGotOe, "R10 write as read", {pGotWrite, pGotOe}, 0);
    hostAcc(1, 3'd1, 8'h00, q, lc);
    chk(q[0] == 1'b0, "R10 no error flag", q, 0);
    hostAcc(0, 3'd2, 8'h04, q, lc);

    // R11 mode disabled
    eppModeEn = 1'b0;
    sc = stbCount;
    hostAcc(0, 3'd4, 8'h77, q, lc);
    repeat (6) @(negedge clk);
    chk(lc == 0 && stbCount == sc, "R11 no transfer", lc, 0);
    eppModeEn = 1'b1;

    finishRun();
  end
endmodule